// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This block is a purely combinational arithmetic unit for operands in sign-magnitude form. Each operand word of W bits carries its sign in the top bit and an unsigned magnitude of W−1 bits below it. The magnitude is the same whether the value is positive or negative. A single select pin picks addition or subtraction. Subtraction is turned into addition by flipping the second operand's sign before any other rule applies.

After that flip, the unit compares the two signs. If they agree, the magnitudes are added and the first operand's sign is kept. A carry out of that addition is reported on the overflow pin. If the signs disagree, the second magnitude is taken from the first through the same adder, by inverting one input and setting the carry in. A missing carry out means the first magnitude was smaller, which is an end borrow. In that case the raw difference is replaced by its two's complement and the result takes the second operand's effective sign. A zero magnitude is always reported with a positive sign.

The unit has no clock and no handshake. It is meant to sit inside a pipeline stage of the surrounding datapath, which registers its inputs and outputs as that stage needs.

Top module: `sm_addsub`

## Requirements
- R1: Both operands and the result are W-bit words: bit W−1 is the sign (0 positive, 1 negative) and bits W−2..0 are an unsigned magnitude.
- R2: With `sub_sel` = 0 the result represents op_m + op_n; with `sub_sel` = 1 it represents op_m − op_n, obtained by inverting op_n's sign bit.
- R3: When the effective signs agree, the result magnitude is the sum of the magnitudes, the result sign is op_m's sign, and `ovf` equals the carry out of that sum.
- R4: When the effective signs differ and op_m's magnitude is at least op_n's, the result magnitude is their difference and the sign is op_m's.
- R5: When the effective signs differ and op_m's magnitude is smaller, the result magnitude is op_n's magnitude minus op_m's, and the sign is op_n's effective sign.
- R6: A result with zero magnitude always has sign bit 0.
- R7: `ovf` is 0 whenever the effective signs differ.
- R8: An operand with zero magnitude and sign 1 (negative zero) acts as the value zero.
- R9: On overflow the result magnitude is the low W−1 bits of the magnitude sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_m | input | W | First operand, sign-magnitude |
| op_n | input | W | Second operand, sign-magnitude |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| res | output | W | Sign-magnitude result |
| ovf | output | 1 | Magnitude sum did not fit in W−1 bits |

## Verification
The checker evaluates, whenever any input changes, that a zero magnitude never comes out negative and that overflow never rises when the effective signs differ. It also checks that the sign follows op_m when the signs agree and follows op_n's effective sign when op_m's magnitude is smaller. The exact magnitude values, the wrap-around on overflow and the equivalence of both zero encodings are shown only by the bench. The bench sweeps every operand pair in both operations and compares each result with signed integer arithmetic.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } sm_op_e;
endpackage

// File: rtl/sm_sign_route.sv
// Splits both operands and resolves the effective sign of op_n.
module sm_sign_route
  import sm_pkg::*;
#(
  parameter int W = 8,
  localparam int MW = W - 1
) (
  input  logic [W-1:0]  op_m,
  input  logic [W-1:0]  op_n,
  input  sm_op_e        op,
  output logic          m_sign,
  output logic          n_sign_eff,
  output logic [MW-1:0] m_mag,
  output logic [MW-1:0] n_mag,
  output logic          same_sign
);
  always_comb begin
    m_sign     = op_m[W-1];
    n_sign_eff = op_n[W-1] ^ (op == OP_SUB);
    m_mag      = op_m[MW-1:0];
    n_mag      = op_n[MW-1:0];
    same_sign  = (m_sign == n_sign_eff);
  end
endmodule

// File: rtl/sm_mag_unit.sv
// Ripple adder on magnitudes; subtracts by inverting b and carrying in 1.
module sm_mag_unit #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  input  logic          do_add,
  output logic [MW-1:0] raw,
  output logic          cout
);
  logic [MW:0]   c;
  logic [MW-1:0] bx;

  assign c[0] = ~do_add;

  for (genvar i = 0; i < MW; i++) begin : g_bit
    assign bx[i]    = do_add ? b[i] : ~b[i];
    assign raw[i]   = a[i] ^ bx[i] ^ c[i];
    assign c[i+1]   = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
  end

  assign cout = c[MW];
endmodule

// File: rtl/sm_fixup.sv
// Applies borrow correction, chooses the sign and suppresses negative zero.
module sm_fixup #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] raw,
  input  logic          cout,
  input  logic          same_sign,
  input  logic          m_sign,
  input  logic          n_sign_eff,
  output logic [MW-1:0] mag,
  output logic          sign,
  output logic          ovf
);
  localparam logic [MW-1:0] ONE = {{(MW-1){1'b0}}, 1'b1};

  logic borrow;

  always_comb begin
    borrow = ~same_sign & ~cout;
    mag    = borrow ? (~raw + ONE) : raw;
    if (mag == '0)
      sign = 1'b0;
    else
      sign = borrow ? n_sign_eff : m_sign;
    ovf    = same_sign & cout;
  end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] op_m,
  input  logic [W-1:0] op_n,
  input  logic         sub_sel,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int MW = W - 1;

  logic          m_sign, n_sign_eff, same_sign;
  logic [MW-1:0] m_mag, n_mag, raw, mag;
  logic          cout, sign;

  sm_sign_route #(.W(W)) u_route (
    .op_m      (op_m),
    .op_n      (op_n),
    .op        (sm_op_e'(sub_sel)),
    .m_sign    (m_sign),
    .n_sign_eff(n_sign_eff),
    .m_mag     (m_mag),
    .n_mag     (n_mag),
    .same_sign (same_sign)
  );

  sm_mag_unit #(.MW(MW)) u_mag (
    .a     (m_mag),
    .b     (n_mag),
    .do_add(same_sign),
    .raw   (raw),
    .cout  (cout)
  );

  sm_fixup #(.MW(MW)) u_fix (
    .raw       (raw),
    .cout      (cout),
    .same_sign (same_sign),
    .m_sign    (m_sign),
    .n_sign_eff(n_sign_eff),
    .mag       (mag),
    .sign      (sign),
    .ovf       (ovf)
  );

  assign res = {sign, mag};
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_m,
  input logic [W-1:0] op_n,
  input logic         sub_sel,
  input logic [W-1:0] res,
  input logic         ovf
);
  localparam int MW = W - 1;

  logic          ns_eff, differ;
  logic [MW-1:0] mm, nm, rm;

  always_comb begin
    ns_eff = op_n[W-1] ^ sub_sel;
    differ = op_m[W-1] != ns_eff;
    mm     = op_m[MW-1:0];
    nm     = op_n[MW-1:0];
    rm     = res[MW-1:0];

    p_zero_positive_r6: assert (!(rm == '0 && res[W-1]));
    p_no_overflow_r7:   assert (!(differ && ovf));
    p_same_sign_r3:     assert (differ || rm == '0 || res[W-1] == op_m[W-1]);
    p_borrow_sign_r5:   assert (!(differ && mm < nm) || res[W-1] == ns_eff);
    p_diff_bound_r4:    assert (!(differ && mm >= nm) || (rm <= mm));
  end
endmodule

bind sm_addsub sm_addsub_chk #(.W(W)) u_chk (
  .op_m   (op_m),
  .op_n   (op_n),
  .sub_sel(sub_sel),
  .res    (res),
  .ovf    (ovf)
);

// File: tb/sim_sm_addsub.sv
`timescale 1ns/1ps
module sim_sm_addsub;
  localparam int W  = 5;
  localparam int MW = W - 1;
  localparam int LIM = 1 << MW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_m = '0, op_n = '0;
  logic         sub_sel = 1'b0;
  logic [W-1:0] res;
  logic         ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sm_addsub #(.W(W)) u0 (
    .op_m(op_m), .op_n(op_n), .sub_sel(sub_sel), .res(res), .ovf(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s m=%b n=%b sub=%0d actual=%0d expected=%0d",
               req, op_m, op_n, sub_sel, act, exp);
    end
  endtask

  task automatic apply(input int m, input int n, input int s);
    @(posedge clk);
    op_m    = W'(m);
    op_n    = W'(n);
    sub_sel = s[0];
    @(negedge clk);
  endtask

  function automatic int smval(input int w);
    int mg = w % LIM;
    return (w >= LIM) ? -mg : mg;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: all-zero operands give a positive zero, no overflow
    check("R1", int'(res), 0);
    check("R1", int'(ovf), 0);

    // R2: 3 - (-2) = +5 -> 0_0101
    apply(5'b00011, 5'b10010, 1);
    check("R2", int'(res), 5);
    // R8: (-0) + (-0) = +0
    apply(5'b10000, 5'b10000, 0);
    check("R8", int'(res), 0);
    // R9: 9 + 9 = 18 -> magnitude 2, ovf
    apply(5'b01001, 5'b01001, 0);
    check("R9", int'(res), 2);
    check("R9", int'(ovf), 1);

    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2*LIM; m++)
        for (int n = 0; n < 2*LIM; n++) begin
          int mv, nv, ev, av, emag, esgn, eovf, mmag, nmag;
          bit same;
          string tag;
          apply(m, n, s);
          mv   = smval(m);
          nv   = smval(n);
          ev   = s ? mv - nv : mv + nv;
          av   = ev < 0 ? -ev : ev;
          emag = av % LIM;
          eovf = (av >= LIM) ? 1 : 0;
          esgn = (ev < 0 && emag != 0) ? 1 : 0;
          mmag = m % LIM;
          nmag = n % LIM;
          same = (m >= LIM) == ((n >= LIM) ^ (s != 0));
          if (eovf != 0)          tag = "R9";
          else if (emag == 0)     tag = "R6";
          else if (mmag == 0 || nmag == 0) tag = "R8";
          else if (same)          tag = "R3";
          else if (mmag >= nmag)  tag = "R4";
          else                    tag = "R5";
          check(tag, int'(res), esgn * LIM + emag);
          check(same ? "R3" : "R7", int'(ovf), eovf);
        end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule